// File: doc/BRIEF.md
# Program Address Trace History Buffer

This block keeps a short record of where a processor's program has been, for inspection by a debug host. Two capture registers follow the program address bus. One loads on each fetch strobe and the other on each decode strobe. Each execute-complete strobe copies the current decode address into a five-entry circular history. When the debug-mode flag rises, all of this state stops changing. The host can then read, at leisure, the fetch address, the decode address and the list of recently executed addresses.

The history has a single read port driven by one strobe. Each strobe returns one entry, one clock later, and moves an internal read index on to the next entry. On entry to debug mode the read index is set to the oldest entry. Five consecutive reads therefore walk the history from oldest to newest, and a sixth read starts the cycle again. The serial debug shifter, the command decoder and the pipeline are outside this block and appear only as strobes.

Top module: `pctrace_history`

## Requirements
- R1: With the debug flag low, a fetch strobe loads the program address bus into the fetch capture output, which shows it from the next clock edge on.
- R2: With the debug flag low, a decode strobe loads the program address bus into the decode capture output, which shows it from the next clock edge on.
- R3: With the debug flag low, an execute strobe stores the decode capture value held before that edge into the history entry at the write index, then advances the write index by one modulo 5. When decode and execute strobes occur in the same cycle, the entry receives the previous decode address.
- R4: The write index and the read index always lie in the range 0 to 4, and both wrap from 4 to 0.
- R5: A read strobe places the history entry at the read index on the read-data output one clock later and advances the read index by one modulo 5 on that same edge.
- R6: A debug entry is a cycle in which the debug flag is high after being low in the previous cycle. It sets the read index to the write index. The first read after entry therefore returns the oldest entry, the fifth returns the newest, and the sixth returns the oldest again. A read in the entry cycle itself is the first read.
- R7: While the debug flag is high, fetch, decode and execute strobes have no effect: both capture outputs, every history entry and the write index keep their values.
- R8: After reset, both capture outputs and every history entry are zero, and both indices are 0.
- R9: The read-data output keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg | input | 1 | Debug-mode flag; high freezes all recorded state |
| pab | input | ADDR_W (16) | Program address bus |
| fetch_stb | input | 1 | Fetch-address strobe |
| decode_stb | input | 1 | Decode-address strobe |
| exec_stb | input | 1 | Execute-complete strobe |
| hist_rd | input | 1 | History read strobe from the debug access port |
| fetch_cap | output | ADDR_W (16) | Fetch capture register |
| decode_cap | output | ADDR_W (16) | Decode capture register |
| hist_q | output | ADDR_W (16) | Registered history read data |

## Verification
The bench halts with a partly filled history and reads more than five times. If the read index is not set to the write index on entry, the unwritten zero entries come out in the wrong positions. If the index wraps late, a stale or out-of-range entry appears as the sixth read. The bench also lets the write index wrap several times and strobes decode and execute in the same cycle. A design that forwards the new decode address would record the wrong entry. The bench pulses every strobe during debug and re-enters debug after a partial read. A design that lets a strobe through would alter a capture output or an entry. One that keeps the old read position would start mid-history. Finally, the bench raises a read in the entry cycle itself, and the oldest entry must come back.

// File: rtl/pctrace_pkg.sv
package pctrace_pkg;

   // Address kinds the block records; used for messages and elaboration checks.
   typedef enum logic [1:0] {
      SRC_FETCH  = 2'd0,
      SRC_DECODE = 2'd1,
      SRC_EXEC   = 2'd2
   } pctrace_src_e;

   // Width of an index able to address DEPTH entries (at least one bit).
   function automatic int idx_bits(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   // True when depth is a power of two, so natural counter overflow wraps.
   function automatic bit is_pow2(input int depth);
      return (depth > 0) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/pctrace_index.sv
module pctrace_index
   import pctrace_pkg::*;
#(
   parameter int DEPTH = 5,
   parameter int IDX_W = idx_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] base,
   output logic [IDX_W-1:0] idx
);

   localparam bit             POW2 = is_pow2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] nxt;

   // Index the step starts from: a load replaces the current value first.
   assign base = load ? load_val : idx;

   generate
      if (POW2) begin : g_wrap_nat
         assign nxt = base + 1'b1;
      end else begin : g_wrap_cmp
         assign nxt = (base == LAST) ? '0 : base + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (step) begin
         idx <= nxt;
      end else if (load) begin
         idx <= load_val;
      end
   end

endmodule

// File: rtl/pctrace_capture.sv
module pctrace_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (en) begin
         q <= d;
      end
   end

endmodule

// File: rtl/pctrace_store.sv
module pctrace_store
   import pctrace_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 5,
   parameter int IDX_W = idx_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_q
);

   logic [W-1:0] ent [DEPTH];
   logic [W-1:0] sel;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
               ent[e] <= wr_data;
            end
         end
      end
   endgenerate

   always_comb begin
      sel = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (rd_idx == IDX_W'(e)) sel = ent[e];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= sel;
      end
   end

endmodule

// File: rtl/pctrace_history.sv
module pctrace_history
   import pctrace_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg,
   input  logic [ADDR_W-1:0] pab,
   input  logic              fetch_stb,
   input  logic              decode_stb,
   input  logic              exec_stb,
   input  logic              hist_rd,
   output logic [ADDR_W-1:0] fetch_cap,
   output logic [ADDR_W-1:0] decode_cap,
   output logic [ADDR_W-1:0] hist_q
);

   localparam int IDX_W = idx_bits(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pctrace_history: DEPTH must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_width
         $error("pctrace_history: ADDR_W must be positive");
      end
   endgenerate

   logic             dbg_q;
   logic             dbg_rise;
   logic             run;
   logic [IDX_W-1:0] wr_ptr;
   logic [IDX_W-1:0] wr_base;
   logic [IDX_W-1:0] rd_ptr;
   logic [IDX_W-1:0] rd_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dbg_q <= 1'b0;
      else        dbg_q <= dbg;
   end

   assign dbg_rise = dbg & ~dbg_q;
   assign run      = ~dbg;

   pctrace_capture #(.W(ADDR_W)) u_fetch (
      .clk (clk), .rst_n (rst_n), .en (run & fetch_stb),
      .d (pab), .q (fetch_cap)
   );

   pctrace_capture #(.W(ADDR_W)) u_decode (
      .clk (clk), .rst_n (rst_n), .en (run & decode_stb),
      .d (pab), .q (decode_cap)
   );

   pctrace_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr_idx (
      .clk (clk), .rst_n (rst_n), .load (1'b0), .load_val ('0),
      .step (run & exec_stb), .base (wr_base), .idx (wr_ptr)
   );

   pctrace_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rd_idx (
      .clk (clk), .rst_n (rst_n), .load (dbg_rise), .load_val (wr_ptr),
      .step (hist_rd), .base (rd_base), .idx (rd_ptr)
   );

   pctrace_store #(.W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk (clk), .rst_n (rst_n),
      .wr_en (run & exec_stb), .wr_idx (wr_base), .wr_data (decode_cap),
      .rd_en (hist_rd), .rd_idx (rd_base), .rd_q (hist_q)
   );

endmodule

// File: rtl/pctrace_history_chk.sv
module pctrace_history_chk
   import pctrace_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 5,
   parameter int IDX_W  = idx_bits(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg,
   input logic [ADDR_W-1:0] pab,
   input logic              fetch_stb,
   input logic              decode_stb,
   input logic              exec_stb,
   input logic              hist_rd,
   input logic [ADDR_W-1:0] fetch_cap,
   input logic [ADDR_W-1:0] decode_cap,
   input logic [ADDR_W-1:0] hist_q,
   input logic [IDX_W-1:0]  rd_ptr,
   input logic [IDX_W-1:0]  wr_ptr,
   input logic              dbg_rise
);

   function automatic logic [IDX_W-1:0] inc(input logic [IDX_W-1:0] x);
      return (int'(x) == DEPTH - 1) ? '0 : x + 1'b1;
   endfunction

   assert_wr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wr_ptr) < DEPTH);

   assert_rd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_ptr) < DEPTH);

   assert_fetch_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stb && !dbg) |=> fetch_cap == $past(pab));

   assert_decode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_stb && !dbg) |=> decode_cap == $past(pab));

   assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && !dbg) |=> wr_ptr == inc($past(wr_ptr)));

   assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_rd && !dbg) |=> rd_ptr == inc($past(rd_ptr)));

   assert_entry_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_rise && !hist_rd) |=> rd_ptr == $past(wr_ptr));

   assert_fetch_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg |=> $stable(fetch_cap));

   assert_decode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg |=> $stable(decode_cap));

   assert_wr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg |=> $stable(wr_ptr));

   assert_q_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hist_rd |=> $stable(hist_q));

endmodule

bind pctrace_history pctrace_history_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/pctrace_history_test.sv
module pctrace_history_test;

   localparam int W = 16;
   localparam int D = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dbg = 1'b0;
   logic [W-1:0] pab = '0;
   logic         fetch_stb = 1'b0, decode_stb = 1'b0, exec_stb = 1'b0, hist_rd = 1'b0;
   logic [W-1:0] fetch_cap, decode_cap, hist_q;

   always #5 clk = ~clk;

   pctrace_history #(.ADDR_W(W), .DEPTH(D)) uut (
      .clk (clk), .rst_n (rst_n), .dbg (dbg), .pab (pab),
      .fetch_stb (fetch_stb), .decode_stb (decode_stb), .exec_stb (exec_stb),
      .hist_rd (hist_rd), .fetch_cap (fetch_cap), .decode_cap (decode_cap),
      .hist_q (hist_q)
   );

   int n_run = 0, n_fail = 0;
   logic [W-1:0] m_hist [D];
   int m_wr = 0, m_rd = 0;
   logic [W-1:0] m_f = '0, m_d = '0, m_last = '0;
   bit m_dbg = 0;

   logic [W-1:0] exp_q [$];
   string        tag_q [$];
   logic         pend = 1'b0;
   bit           done = 0;

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: compares registered read data one clock after each read strobe.
   always @(posedge clk) pend <= hist_rd;
   always @(negedge clk) begin
      if (pend && exp_q.size() > 0) begin
         logic [W-1:0] e;
         string        t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(hist_q, e, t);
      end
   end

   task automatic fetch(input logic [W-1:0] a);
      pab = a; fetch_stb = 1'b1;
      @(negedge clk); fetch_stb = 1'b0;
      if (!m_dbg) m_f = a;
   endtask

   task automatic decode(input logic [W-1:0] a);
      pab = a; decode_stb = 1'b1;
      @(negedge clk); decode_stb = 1'b0;
      if (!m_dbg) m_d = a;
   endtask

   task automatic execute();
      exec_stb = 1'b1;
      @(negedge clk); exec_stb = 1'b0;
      if (!m_dbg) begin m_hist[m_wr] = m_d; m_wr = (m_wr + 1) % D; end
   endtask

   task automatic instr(input logic [W-1:0] a);
      fetch(a); decode(a + 16'h0100); execute();
   endtask

   task automatic hist_read(input string req);
      exp_q.push_back(m_hist[m_rd]); tag_q.push_back(req);
      m_last = m_hist[m_rd];
      m_rd = (m_rd + 1) % D;
      hist_rd = 1'b1;
      @(negedge clk); hist_rd = 1'b0;
   endtask

   task automatic enter_dbg();
      dbg = 1'b1; m_dbg = 1; m_rd = m_wr;
      @(negedge clk);
   endtask

   task automatic leave_dbg();
      dbg = 1'b0; m_dbg = 0;
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < D; i++) m_hist[i] = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(fetch_cap, 16'h0000, "R8");
      check(decode_cap, 16'h0000, "R8");
      check(hist_q, 16'h0000, "R8");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: capture loads
      fetch(16'h1234);
      check(fetch_cap, 16'h1234, "R1");
      decode(16'hBEEF);
      check(decode_cap, 16'hBEEF, "R2");
      execute();

      // partly filled history: 3 entries, then halt and read seven times (R6, R5, R4)
      instr(16'h0010); instr(16'h0020);
      enter_dbg();
      for (int k = 0; k < 7; k++) hist_read("R6");
      repeat (3) @(negedge clk);
      check(hist_q, m_last, "R9");

      // R7: strobes in debug are ignored
      fetch(16'hAAAA); decode(16'hBBBB); execute(); execute();
      check(fetch_cap, m_f, "R7");
      check(decode_cap, m_d, "R7");
      for (int k = 0; k < 5; k++) hist_read("R7");
      leave_dbg();

      // write index wraps several times (R3, R4)
      for (int k = 0; k < 12; k++) instr(16'h2000 + 16'(k * 4));
      enter_dbg();
      for (int k = 0; k < 6; k++) hist_read("R4");
      leave_dbg();

      // R3: same-cycle decode and execute store the previous decode address
      pab = 16'h7777; decode_stb = 1'b1; exec_stb = 1'b1;
      @(negedge clk); decode_stb = 1'b0; exec_stb = 1'b0;
      m_hist[m_wr] = m_d; m_wr = (m_wr + 1) % D; m_d = 16'h7777;
      check(decode_cap, 16'h7777, "R2");
      execute();

      // R5 outside debug: reads advance the index freely
      hist_read("R5"); hist_read("R5");

      // R6: re-entry after partial read starts at oldest again
      enter_dbg();
      hist_read("R6"); hist_read("R6");
      leave_dbg();
      enter_dbg();
      for (int k = 0; k < 5; k++) hist_read("R6");
      leave_dbg();

      // R6: read in the entry cycle itself returns the oldest entry
      instr(16'h4444);
      dbg = 1'b1; m_dbg = 1; m_rd = m_wr;
      hist_read("R6");
      hist_read("R6");
      leave_dbg();
      repeat (3) @(negedge clk);
      check(hist_q, m_last, "R9");
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule